// File: doc/BRIEF.md
# Auto-Reload Prescaled Down Timer

This block is an 8-bit down counter that divides the main clock through a free-running prescaler and one of two taps. A fast tap produces a tick every 4 clock cycles and a slow tap produces a tick every 1024 clock cycles. A mode bit selects the tap, and a second mode bit starts and stops counting. Software places the reload value in a buffer with two nibble writes. The counter decrements once per tick. When it reaches the end of its range it reloads from the buffer and raises an event flag.

The event flag feeds two paths that are gated independently. An interrupt-request level appears while the flag is set and the interrupt enable is high. A hold-release path produces a one-cycle request and latches a hold-cause flag, but only for underflows that occur while the hold enable is high. A masked clear command removes the flags. Clock generation, the processor and interrupt vectoring sit outside this block.

Top module: `reload_down_timer`

## Requirements
- R1: After reset the counter, the reload buffer, the mode bits, the event flag, the hold-cause flag and every request output are all zero.
- R2: Counting is enabled by mode bit 3, written through `wr_mode`. While this bit is 0 the counter keeps its value, whatever ticks or buffer writes occur.
- R3: Mode bit 0 selects the tick source. A value of 0 gives one tick every 2^FAST_SHIFT clock cycles and a value of 1 gives one tick every 2^SLOW_SHIFT clock cycles. Both taps come from a prescaler that runs freely from reset.
- R4: When no load is armed, each enabled tick lowers the counter by one. A tick that finds the counter at 1 is an underflow: the counter takes the buffer value, so a reload value N gives one underflow every N ticks.
- R5: A reload value of 0 gives an underflow period of 256 ticks.
- R6: `wr_lo` writes `wr_data` into buffer bits 3:0 and does not change the counter.
- R7: `wr_hi` writes `wr_data` into buffer bits 7:4 and arms a load. The next enabled tick copies the whole buffer into the counter. This load takes the place of a decrement or an underflow, so it raises no event.
- R8: `evt_flag` rises in the cycle after an underflow. A clear command (`clr_valid` with `clr_mask` bit 0 set) drops it. With `clr_mask` bit 0 at 0 the command leaves the flag unchanged.
- R9: When a clear of the event flag and an underflow fall in the same cycle, the flag stays set.
- R10: `irq_req` is high exactly while `evt_flag` is high and `irq_en` is high.
- R11: An underflow with `hold_en` high gives a one-cycle `hold_req` pulse, aligned with the rise of the flag, and sets `hold_cause`. `hold_cause` is cleared by a clear command with `clr_mask` bit 1 set. An underflow with `hold_en` low produces neither output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_lo | input | 1 | Write strobe for the low nibble of the reload buffer |
| wr_hi | input | 1 | Write strobe for the high nibble of the reload buffer; arms a load |
| wr_mode | input | 1 | Write strobe for the mode register (bit 0 tap, bit 3 run) |
| wr_data | input | NIB_W | Write data shared by the three strobes |
| clr_valid | input | 1 | Clear command strobe |
| clr_mask | input | 2 | Clear mask: bit 0 event flag, bit 1 hold cause |
| irq_en | input | 1 | Interrupt path enable |
| hold_en | input | 1 | Hold-release path enable |
| count_o | output | 2*NIB_W | Current counter value |
| evt_flag | output | 1 | Underflow event flag |
| irq_req | output | 1 | Interrupt request level |
| hold_req | output | 1 | One-cycle hold-release request |
| hold_cause | output | 1 | Records that an underflow released hold |

## Verification
The bench builds the block with FAST_SHIFT=2 and SLOW_SHIFT=6 (64 cycles per slow tick), and keeps the 8-bit counter. With these values a full 256-tick period on the slow tap fits in a short run. The bench can then sweep reload values 1 through 40, several large values and the zero case on the fast tap, and check each period against N times the tap divisor. The small reload value 1 gives an underflow every fourth cycle, which puts the clear-versus-underflow collision at a predictable cycle.

// File: rtl/rdt_pkg.sv
`timescale 1ns/1ps
package rdt_pkg;
    localparam int MODE_TAP_BIT  = 0;
    localparam int MODE_RUN_BIT  = 3;
    localparam int CLR_EVT_BIT   = 0;
    localparam int CLR_CAUSE_BIT = 1;

    typedef enum logic {
        TAP_FAST = 1'b0,
        TAP_SLOW = 1'b1
    } tap_sel_e;
endpackage

// File: rtl/rdt_prescaler.sv
`timescale 1ns/1ps
module rdt_prescaler #(
    parameter int FAST_SHIFT = 2,
    parameter int SLOW_SHIFT = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tap_slow,
    output logic tick
);
    localparam int PRE_W = SLOW_SHIFT;
    localparam logic [PRE_W-1:0] PRE_ONE = PRE_W'(1);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } pre_state_t;

    pre_state_t st_d, st_q;
    logic fast_hit;
    logic slow_hit;

    generate
        if (FAST_SHIFT == 0) begin : g_fast_every
            assign fast_hit = 1'b1;
        end else begin : g_fast_tap
            assign fast_hit = &st_q.pre[FAST_SHIFT-1:0];
        end
    endgenerate

    assign slow_hit = &st_q.pre;

    always_comb begin
        st_d     = st_q;
        st_d.pre = st_q.pre + PRE_ONE;
        tick     = tap_slow ? slow_hit : fast_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/rdt_mode_reg.sv
`timescale 1ns/1ps
module rdt_mode_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_mode,
    input  logic       run_bit,
    input  logic       tap_bit,
    output logic       run_en,
    output logic       tap_slow
);
    import rdt_pkg::*;

    typedef struct packed {
        logic     run;
        tap_sel_e tap;
    } mode_state_t;

    mode_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_mode) begin
            st_d.run = run_bit;
            st_d.tap = tap_bit ? TAP_SLOW : TAP_FAST;
        end
        run_en   = st_q.run;
        tap_slow = (st_q.tap == TAP_SLOW);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{run: 1'b0, tap: TAP_FAST};
        else        st_q <= st_d;
    end
endmodule

// File: rtl/rdt_counter.sv
`timescale 1ns/1ps
module rdt_counter #(
    parameter int NIB_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_lo,
    input  logic               wr_hi,
    input  logic [NIB_W-1:0]   wr_data,
    input  logic               tick,
    input  logic               run_en,
    output logic [2*NIB_W-1:0] count,
    output logic               underflow
);
    localparam int CNT_W = 2 * NIB_W;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] buf_v;
        logic             arm;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic step;

    always_comb begin
        st_d      = st_q;
        step      = tick & run_en;
        underflow = step & ~st_q.arm & (st_q.cnt == CNT_ONE);

        if (wr_lo) st_d.buf_v[NIB_W-1:0] = wr_data;
        if (wr_hi) begin
            st_d.buf_v[CNT_W-1:NIB_W] = wr_data;
            st_d.arm                  = 1'b1;
        end

        if (step) begin
            if (st_q.arm) begin
                st_d.cnt = st_q.buf_v;
                st_d.arm = wr_hi;
            end else if (underflow) begin
                st_d.cnt = st_q.buf_v;
            end else begin
                st_d.cnt = st_q.cnt - CNT_ONE;
            end
        end

        count = st_q.cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/rdt_event.sv
`timescale 1ns/1ps
module rdt_event (
    input  logic clk,
    input  logic rst_n,
    input  logic underflow,
    input  logic clr_evt,
    input  logic clr_cause,
    input  logic irq_en,
    input  logic hold_en,
    output logic evt_flag,
    output logic hold_cause,
    output logic hold_req,
    output logic irq_req
);
    typedef struct packed {
        logic evt;
        logic cause;
        logic hreq;
    } evt_state_t;

    evt_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.evt   = (st_q.evt & ~clr_evt) | underflow;
        st_d.cause = (st_q.cause & ~clr_cause) | (underflow & hold_en);
        st_d.hreq  = underflow & hold_en;

        evt_flag   = st_q.evt;
        hold_cause = st_q.cause;
        hold_req   = st_q.hreq;
        irq_req    = st_q.evt & irq_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/reload_down_timer.sv
`timescale 1ns/1ps
module reload_down_timer #(
    parameter int NIB_W      = 4,
    parameter int FAST_SHIFT = 2,
    parameter int SLOW_SHIFT = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_lo,
    input  logic               wr_hi,
    input  logic               wr_mode,
    input  logic [NIB_W-1:0]   wr_data,
    input  logic               clr_valid,
    input  logic [1:0]         clr_mask,
    input  logic               irq_en,
    input  logic               hold_en,
    output logic [2*NIB_W-1:0] count_o,
    output logic               evt_flag,
    output logic               irq_req,
    output logic               hold_req,
    output logic               hold_cause
);
    import rdt_pkg::*;

    localparam int CNT_W = 2 * NIB_W;

    logic tick_w;
    logic run_en_w;
    logic tap_slow_w;
    logic uf_w;
    logic clr_evt_w;
    logic clr_cause_w;

    assign clr_evt_w   = clr_valid & clr_mask[CLR_EVT_BIT];
    assign clr_cause_w = clr_valid & clr_mask[CLR_CAUSE_BIT];

    rdt_mode_reg u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_mode  (wr_mode),
        .run_bit  (wr_data[MODE_RUN_BIT]),
        .tap_bit  (wr_data[MODE_TAP_BIT]),
        .run_en   (run_en_w),
        .tap_slow (tap_slow_w)
    );

    rdt_prescaler #(
        .FAST_SHIFT (FAST_SHIFT),
        .SLOW_SHIFT (SLOW_SHIFT)
    ) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .tap_slow (tap_slow_w),
        .tick     (tick_w)
    );

    rdt_counter #(
        .NIB_W (NIB_W)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_lo     (wr_lo),
        .wr_hi     (wr_hi),
        .wr_data   (wr_data),
        .tick      (tick_w),
        .run_en    (run_en_w),
        .count     (count_o),
        .underflow (uf_w)
    );

    rdt_event u_evt (
        .clk        (clk),
        .rst_n      (rst_n),
        .underflow  (uf_w),
        .clr_evt    (clr_evt_w),
        .clr_cause  (clr_cause_w),
        .irq_en     (irq_en),
        .hold_en    (hold_en),
        .evt_flag   (evt_flag),
        .hold_cause (hold_cause),
        .hold_req   (hold_req),
        .irq_req    (irq_req)
    );
endmodule

// File: rtl/rdt_checker.sv
`timescale 1ns/1ps
module rdt_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             run_en,
    input logic             underflow,
    input logic             clr_evt,
    input logic             hold_en,
    input logic [CNT_W-1:0] count_o,
    input logic             evt_flag,
    input logic             irq_req,
    input logic             hold_req,
    input logic             hold_cause
);
    p_stopped_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> $stable(count_o));

    p_tick_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    p_uf_sets_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> evt_flag);

    p_fall_needs_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(evt_flag) |-> $past(clr_evt));

    p_collision_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (underflow && clr_evt) |=> evt_flag);

    p_irq_needs_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_flag |-> !irq_req);

    p_hreq_with_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
        hold_req |-> (hold_cause && evt_flag));

    p_cause_needs_en_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_cause) |-> $past(hold_en));
endmodule

bind reload_down_timer rdt_checker #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick_w),
    .run_en     (run_en_w),
    .underflow  (uf_w),
    .clr_evt    (clr_evt_w),
    .hold_en    (hold_en),
    .count_o    (count_o),
    .evt_flag   (evt_flag),
    .irq_req    (irq_req),
    .hold_req   (hold_req),
    .hold_cause (hold_cause)
);

// File: tb/reload_down_timer_tb.sv
`timescale 1ns/1ps
module reload_down_timer_tb;
    localparam int NIB_W      = 4;
    localparam int FAST_SHIFT = 2;
    localparam int SLOW_SHIFT = 6;
    localparam int CNT_W      = 2 * NIB_W;
    localparam int FAST_DIV   = 1 << FAST_SHIFT;
    localparam int SLOW_DIV   = 1 << SLOW_SHIFT;
    localparam int WATCHDOG   = 150000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_lo = 1'b0, wr_hi = 1'b0, wr_mode = 1'b0;
    logic [NIB_W-1:0] wr_data = '0;
    logic             clr_valid = 1'b0;
    logic [1:0]       clr_mask = 2'b00;
    logic             irq_en = 1'b0, hold_en = 1'b0;
    logic [CNT_W-1:0] count_o;
    logic             evt_flag, irq_req, hold_req, hold_cause;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    reload_down_timer #(
        .NIB_W (NIB_W), .FAST_SHIFT (FAST_SHIFT), .SLOW_SHIFT (SLOW_SHIFT)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .wr_lo (wr_lo), .wr_hi (wr_hi),
        .wr_mode (wr_mode), .wr_data (wr_data), .clr_valid (clr_valid),
        .clr_mask (clr_mask), .irq_en (irq_en), .hold_en (hold_en),
        .count_o (count_o), .evt_flag (evt_flag), .irq_req (irq_req),
        .hold_req (hold_req), .hold_cause (hold_cause)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WATCHDOG && !done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic check_eq(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic strobe_lo(input logic [NIB_W-1:0] d);
        wr_lo = 1'b1; wr_data = d; @(negedge clk); wr_lo = 1'b0;
    endtask

    task automatic strobe_hi(input logic [NIB_W-1:0] d);
        wr_hi = 1'b1; wr_data = d; @(negedge clk); wr_hi = 1'b0;
    endtask

    task automatic set_mode(input bit run, input bit slow);
        wr_mode = 1'b1; wr_data = {run, 2'b00, slow}; @(negedge clk); wr_mode = 1'b0;
    endtask

    task automatic clear(input logic [1:0] m);
        clr_valid = 1'b1; clr_mask = m; @(negedge clk); clr_valid = 1'b0; clr_mask = 2'b00;
    endtask

    task automatic load(input int n);
        strobe_lo(NIB_W'(n));
        strobe_hi(NIB_W'(n >> NIB_W));
    endtask

    task automatic wait_flag(output int t);
        for (int n = 0; n < 40000 && !evt_flag; n++) @(negedge clk);
        if (!evt_flag) check_eq("R8 flag timeout", 0, 1);
        t = cyc;
    endtask

    task automatic wait_change(input string req);
        logic [CNT_W-1:0] start;
        start = count_o;
        for (int n = 0; n < 400 && count_o == start; n++) @(negedge clk);
        if (count_o == start) check_eq(req, count_o, 32'(start) ^ 1);
    endtask

    task automatic measure(input int n, input bit slow);
        int t1, t2, exp;
        string tag;
        set_mode(1'b0, slow);
        load(n);
        clear(2'b11);
        set_mode(1'b1, slow);
        wait_flag(t1);
        clear(2'b01);
        wait_flag(t2);
        exp = (n == 0 ? 256 : n) * (slow ? SLOW_DIV : FAST_DIV);
        tag = (n == 0) ? "R5 zero reload period" : (slow ? "R3 slow tap period" : "R4 fast period");
        check_eq(tag, t2 - t1, exp);
    endtask

    initial begin
        int t;
        logic [CNT_W-1:0] c;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check_eq("R1 count", count_o, 0);
        check_eq("R1 evt_flag", evt_flag, 0);
        check_eq("R1 irq_req", irq_req, 0);
        check_eq("R1 hold_req", hold_req, 0);
        check_eq("R1 hold_cause", hold_cause, 0);

        // R2 not running: counter idle
        repeat (40) @(negedge clk);
        check_eq("R2 idle count", count_o, 0);
        check_eq("R2 idle flag", evt_flag, 0);

        // R4 / R5 / R3 period sweeps
        for (int n = 1; n <= 40; n++) measure(n, 1'b0);
        measure(8'h80, 1'b0);
        measure(8'hFF, 1'b0);
        measure(0, 1'b0);
        measure(1, 1'b1);
        measure(3, 1'b1);
        measure(16, 1'b1);
        measure(0, 1'b1);

        // R8 mask: stop, flag remains; mask bit 1 only leaves it
        set_mode(1'b0, 1'b0);
        @(negedge clk);
        check_eq("R8 flag held while stopped", evt_flag, 1);
        clear(2'b10);
        check_eq("R8 unmasked clear ignored", evt_flag, 1);
        clear(2'b01);
        check_eq("R8 masked clear", evt_flag, 0);

        // R6 / R7 nibble write behaviour
        load(8'h35);
        set_mode(1'b1, 1'b0);
        wait_change("R7 arm load");
        check_eq("R7 armed load value", count_o, 8'h35);
        repeat (3) wait_change("R4 decrement");
        set_mode(1'b0, 1'b0);
        c = count_o;
        strobe_lo(4'hA);
        repeat (20) @(negedge clk);
        check_eq("R6 low write leaves counter", count_o, c);
        set_mode(1'b1, 1'b0);
        wait_change("R6 resume");
        check_eq("R6 decrement after low write", count_o, 32'(c) - 1);
        set_mode(1'b0, 1'b0);
        c = count_o;
        strobe_hi(4'h4);
        repeat (20) @(negedge clk);
        check_eq("R2 high write while stopped", count_o, c);
        set_mode(1'b1, 1'b0);
        wait_change("R7 resume");
        check_eq("R7 buffer copy", count_o, 8'h4A);
        wait_change("R4 after load");
        check_eq("R4 decrement after load", count_o, 8'h49);

        // R9 collision with reload 1 (underflow every FAST_DIV cycles)
        set_mode(1'b0, 1'b0);
        load(1);
        set_mode(1'b1, 1'b0);
        clear(2'b11);
        wait_flag(t);
        repeat (FAST_DIV - 1) @(negedge clk);
        clr_valid = 1'b1; clr_mask = 2'b01;
        @(negedge clk);
        clr_valid = 1'b0; clr_mask = 2'b00;
        check_eq("R9 clear with underflow", evt_flag, 1);
        clear(2'b01);
        check_eq("R8 clear between underflows", evt_flag, 0);

        // R10 / R11 request paths
        set_mode(1'b0, 1'b0);
        load(5);
        hold_en = 1'b1;
        irq_en  = 1'b0;
        clear(2'b11);
        set_mode(1'b1, 1'b0);
        wait_flag(t);
        check_eq("R11 hold_req pulse", hold_req, 1);
        check_eq("R10 irq gated off", irq_req, 0);
        @(negedge clk);
        check_eq("R11 hold_req one cycle", hold_req, 0);
        check_eq("R11 hold_cause latched", hold_cause, 1);
        irq_en = 1'b1;
        #1;
        check_eq("R10 irq with flag", irq_req, 1);
        hold_en = 1'b0;
        clear(2'b11);
        check_eq("R11 cause cleared", hold_cause, 0);
        wait_flag(t);
        check_eq("R11 no hold_req when disabled", hold_req, 0);
        check_eq("R10 irq follows flag", irq_req, 1);
        @(negedge clk);
        check_eq("R11 no cause when disabled", hold_cause, 0);
        set_mode(1'b0, 1'b0);
        clear(2'b01);
        check_eq("R10 irq drops with flag", irq_req, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule